// File: doc/BRIEF.md
# Page-Not-Present Fault Capture

This block watches two access streams every clock: an instruction fetch and a data-side access. The data side covers loads, stores, semaphores, non-access operations and register-stack mandatory fill/spill. For each stream it takes the present bit of the translation entry that the external lookup matched, together with the translation-enable bit for that class of access. If the present bit is clear and translation is on for that class, the block raises a one-cycle fault strobe.

On the same clock edge as the strobe, the block loads three capture registers. The fault-address register gets the faulting virtual address. The translation-info register gets a default word built from the referenced region register. The status register gets a word that describes the access. The registers hold their values until the next fault or a reset.

A constant output supplies the offset of the interruption vector. When both streams fault in the same cycle, the instruction fetch is reported and the data fault is dropped.

Top module: `pnp_fault_capture`

## Requirements
- R1: `pf_vec` always equals 16'h5000, the vector offset for this fault.
- R2: A fault is raised only for a requesting stream whose present bit is 0. An instruction fetch also needs `xlat_it_en`=1. Data kinds 0 (load), 1 (store), 2 (semaphore) and 3 (non-access) need `xlat_dt_en`=1. Kinds 4 (stack fill) and 5 (stack spill) need `xlat_rs_en`=1. Kinds 6 and 7 never fault.
- R3: `pf_fault` is high for exactly the cycle after the one in which the fault conditions were sampled. `pf_inst`, `pf_addr`, `pf_xinfo` and `pf_status` load on that same edge and keep their values while no fault occurs. Reset clears all of them to 0.
- R4: `pf_xinfo` is {rid, ps, 2'b00}. The rid and ps come from the region inputs of the stream that faulted.
- R5: For a data fault, `pf_addr` is `dt_va`. For an instruction fault, `pf_addr` is `if_va`. When `if_legacy`=1 it is instead {32'b0, if_va[31:4], 4'b0}.
- R6: The status word has this layout: [3:0] code, [4] r, [5] w, [6] x, [7] na, [8] sp, [9] rs, [10] ir, [11] ni, [13:12] ei, [14] ed, [15] 0. For a data fault, code is `dt_nacode` for kind 3 and 0 otherwise. r is set for kinds 0, 2 and 4, and w for kinds 1, 2 and 5. na is set for kind 3 and rs for kinds 4 and 5. ni = `dt_ni`, ei = `dt_slot` and ed = `dt_ed`. sp, ir and x are 0.
- R7: On a data fault, ed is 0 for kinds 4 and 5. When `dt_legacy`=1, code, ed, ei, ni, ir, rs, sp and na are all 0, and r and w are kept.
- R8: For an instruction fault, the status word has x=1 and ei = `if_slot`, ni = `if_ni`. Every other bit is 0. With `if_legacy`=1, ei and ni are 0 as well. `pf_inst` is 1 for an instruction fault and 0 for a data fault.
- R9: When both streams fault in the same cycle, the instruction fault is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xlat_it_en | input | 1 | Instruction translation enable |
| xlat_dt_en | input | 1 | Data translation enable |
| xlat_rs_en | input | 1 | Register-stack translation enable |
| if_req | input | 1 | Instruction fetch valid |
| if_present | input | 1 | Present bit of matched instruction entry |
| if_va | input | VA_W | Fetch virtual address |
| if_slot | input | 2 | Slot index of the faulting instruction |
| if_legacy | input | 1 | Fetch is in legacy 32-bit mode |
| if_ni | input | 1 | Fetch ni flag |
| if_rid | input | RID_W | Region id for fetch region |
| if_ps | input | PS_W | Page size for fetch region |
| dt_req | input | 1 | Data access valid |
| dt_present | input | 1 | Present bit of matched data entry |
| dt_kind | input | 3 | Data access kind (see R2) |
| dt_va | input | VA_W | Data virtual address |
| dt_legacy | input | 1 | Data access is a legacy 32-bit reference |
| dt_nacode | input | 4 | Non-access operation type |
| dt_slot | input | 2 | Slot of issuing instruction |
| dt_ni | input | 1 | Data ni flag |
| dt_ed | input | 1 | Data ed flag |
| dt_rid | input | RID_W | Region id for data region |
| dt_ps | input | PS_W | Page size for data region |
| pf_fault | output | 1 | Fault strobe |
| pf_vec | output | 16 | Vector offset |
| pf_inst | output | 1 | Captured fault was an instruction fetch |
| pf_addr | output | VA_W | Captured fault address |
| pf_xinfo | output | RID_W+PS_W+2 | Captured default translation info |
| pf_status | output | 16 | Captured status word |

## Verification
An instruction fetch fault and a data fault can arrive in the same cycle, and only one set of captures can be written. The bench drives both streams in one cycle with both present bits clear and their enables set. It gives each stream a distinct address and region so the winner can be told apart. It then checks that the address, translation info, status and `pf_inst` all match the fetch. A second case lets the data stream fault while the fetch is present, to confirm that the data capture still goes through when the fetch is clean.

// File: rtl/pnp_fault_capture.sv
module pnp_fault_capture #(
  parameter int VA_W  = 64,
  parameter int RID_W = 24,
  parameter int PS_W  = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    xlat_it_en,
  input  logic                    xlat_dt_en,
  input  logic                    xlat_rs_en,
  input  logic                    if_req,
  input  logic                    if_present,
  input  logic [VA_W-1:0]         if_va,
  input  logic [1:0]              if_slot,
  input  logic                    if_legacy,
  input  logic                    if_ni,
  input  logic [RID_W-1:0]        if_rid,
  input  logic [PS_W-1:0]         if_ps,
  input  logic                    dt_req,
  input  logic                    dt_present,
  input  logic [2:0]              dt_kind,
  input  logic [VA_W-1:0]         dt_va,
  input  logic                    dt_legacy,
  input  logic [3:0]              dt_nacode,
  input  logic [1:0]              dt_slot,
  input  logic                    dt_ni,
  input  logic                    dt_ed,
  input  logic [RID_W-1:0]        dt_rid,
  input  logic [PS_W-1:0]         dt_ps,
  output logic                    pf_fault,
  output logic [15:0]             pf_vec,
  output logic                    pf_inst,
  output logic [VA_W-1:0]         pf_addr,
  output logic [RID_W+PS_W+1:0]   pf_xinfo,
  output logic [15:0]             pf_status
);
  localparam int XI_W = RID_W + PS_W + 2;

  assign pf_vec = 16'h5000;

  logic k_ld, k_st, k_sem, k_na, k_fill, k_spill, k_rse, d_en;
  assign k_ld    = (dt_kind == 3'd0);
  assign k_st    = (dt_kind == 3'd1);
  assign k_sem   = (dt_kind == 3'd2);
  assign k_na    = (dt_kind == 3'd3);
  assign k_fill  = (dt_kind == 3'd4);
  assign k_spill = (dt_kind == 3'd5);
  assign k_rse   = k_fill | k_spill;
  assign d_en    = k_rse ? xlat_rs_en : ((k_ld | k_st | k_sem | k_na) & xlat_dt_en);

  logic i_hit, d_hit, hit_any;
  assign i_hit   = if_req & ~if_present & xlat_it_en;
  assign d_hit   = dt_req & ~dt_present & d_en;
  assign hit_any = i_hit | d_hit;

  logic [VA_W-1:0] i_addr;
  generate
    if (VA_W > 32) begin : g_wide
      assign i_addr = if_legacy ? {{(VA_W-32){1'b0}}, if_va[31:4], 4'b0000} : if_va;
    end else begin : g_narrow
      assign i_addr = if_legacy ? {if_va[VA_W-1:4], 4'b0000} : if_va;
    end
  endgenerate

  logic [15:0] i_stat, d_stat;
  logic [1:0]  i_ei;
  logic        i_ni;
  assign i_ei   = if_legacy ? 2'b00 : if_slot;
  assign i_ni   = if_legacy ? 1'b0  : if_ni;
  assign i_stat = {1'b0, 1'b0, i_ei, i_ni, 4'b0000, 1'b1, 2'b00, 4'b0000};

  logic [3:0] d_code;
  logic       d_r, d_w, d_na, d_rs, d_ed, d_ni;
  logic [1:0] d_ei;
  assign d_r    = k_ld | k_sem | k_fill;
  assign d_w    = k_st | k_sem | k_spill;
  assign d_code = (k_na && !dt_legacy) ? dt_nacode : 4'h0;
  assign d_na   = k_na & ~dt_legacy;
  assign d_rs   = k_rse & ~dt_legacy;
  assign d_ed   = dt_ed & ~k_rse & ~dt_legacy;
  assign d_ni   = dt_ni & ~dt_legacy;
  assign d_ei   = dt_legacy ? 2'b00 : dt_slot;
  assign d_stat = {1'b0, d_ed, d_ei, d_ni, 1'b0, d_rs, 1'b0, d_na, 1'b0, d_w, d_r, d_code};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pf_fault  <= 1'b0;
      pf_inst   <= 1'b0;
      pf_addr   <= '0;
      pf_xinfo  <= '0;
      pf_status <= '0;
    end else begin
      pf_fault <= hit_any;
      if (i_hit) begin
        pf_inst   <= 1'b1;
        pf_addr   <= i_addr;
        pf_xinfo  <= {if_rid, if_ps, 2'b00};
        pf_status <= i_stat;
      end else if (d_hit) begin
        pf_inst   <= 1'b0;
        pf_addr   <= dt_va;
        pf_xinfo  <= {dt_rid, dt_ps, 2'b00};
        pf_status <= d_stat;
      end
    end
  end

  AST_NO_EN_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (!xlat_it_en && !xlat_dt_en && !xlat_rs_en) |=> !pf_fault); // R2
  AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_any |=> ($stable(pf_addr) && $stable(pf_status) && $stable(pf_xinfo))); // R3
  AST_INST_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    i_hit |=> (pf_fault && pf_inst)); // R9
  AST_INST_NO_RW: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_fault && pf_inst) |-> (pf_status[6] && !pf_status[5] && !pf_status[4])); // R8
  AST_RSE_ED_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_fault && !pf_inst && pf_status[9]) |-> !pf_status[14]); // R7
  AST_XINFO_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    pf_fault |-> (pf_xinfo[1:0] == 2'b00)); // R4
  AST_VEC_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    pf_fault |-> (pf_vec == 16'h5000)); // R1

  logic unused_w;
  assign unused_w = ^{XI_W[0]};
endmodule

// File: tb/pnp_fault_capture_tb.sv
`timescale 1ns/1ps
module pnp_fault_capture_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n;
  logic it_en, dt_en, rs_en;
  logic if_req, if_present, if_legacy, if_ni;
  logic [63:0] if_va, dt_va;
  logic [1:0]  if_slot, dt_slot;
  logic [23:0] if_rid, dt_rid;
  logic [5:0]  if_ps, dt_ps;
  logic dt_req, dt_present, dt_legacy, dt_ni, dt_ed;
  logic [2:0] dt_kind;
  logic [3:0] dt_nacode;
  logic pf_fault, pf_inst;
  logic [15:0] pf_vec, pf_status;
  logic [63:0] pf_addr;
  logic [31:0] pf_xinfo;

  pnp_fault_capture u_dut (
    .clk(clk), .rst_n(rst_n),
    .xlat_it_en(it_en), .xlat_dt_en(dt_en), .xlat_rs_en(rs_en),
    .if_req(if_req), .if_present(if_present), .if_va(if_va), .if_slot(if_slot),
    .if_legacy(if_legacy), .if_ni(if_ni), .if_rid(if_rid), .if_ps(if_ps),
    .dt_req(dt_req), .dt_present(dt_present), .dt_kind(dt_kind), .dt_va(dt_va),
    .dt_legacy(dt_legacy), .dt_nacode(dt_nacode), .dt_slot(dt_slot), .dt_ni(dt_ni),
    .dt_ed(dt_ed), .dt_rid(dt_rid), .dt_ps(dt_ps),
    .pf_fault(pf_fault), .pf_vec(pf_vec), .pf_inst(pf_inst), .pf_addr(pf_addr),
    .pf_xinfo(pf_xinfo), .pf_status(pf_status));

  int n_chk = 0, n_bad = 0;
  logic [63:0] e_addr;
  logic [31:0] e_xinfo;
  logic [15:0] e_stat;
  logic        e_inst;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] dstat(input logic [2:0] k, input logic leg, input logic [3:0] nac,
                                        input logic [1:0] sl, input logic ni, input logic ed);
    logic r, w, na, rs, edb; logic [3:0] c; logic [1:0] ei; logic nib;
    r  = (k == 0) || (k == 2) || (k == 4);
    w  = (k == 1) || (k == 2) || (k == 5);
    na = (k == 3);
    rs = (k >= 4);
    c  = na ? nac : 4'h0;
    edb = rs ? 1'b0 : ed;
    ei = sl; nib = ni;
    if (leg) begin c = 0; edb = 0; ei = 0; nib = 0; na = 0; rs = 0; end
    return {1'b0, edb, ei, nib, 1'b0, rs, 1'b0, na, 1'b0, w, r, c};
  endfunction

  task automatic idle();
    if_req = 0; dt_req = 0; if_present = 1; dt_present = 1;
  endtask

  task automatic check_caps(input string req, input logic exp_fault);
    chk({req, " strobe"}, {63'b0, pf_fault}, {63'b0, exp_fault});
    chk({req, " addr"}, pf_addr, e_addr);
    chk({req, " xinfo"}, {32'b0, pf_xinfo}, {32'b0, e_xinfo});
    chk({req, " status"}, {48'b0, pf_status}, {48'b0, e_stat});
    chk({req, " inst"}, {63'b0, pf_inst}, {63'b0, e_inst});
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; it_en = 0; dt_en = 0; rs_en = 0; idle();
    if_va = 0; dt_va = 0; if_slot = 0; dt_slot = 0; if_legacy = 0; dt_legacy = 0;
    if_ni = 0; dt_ni = 0; dt_ed = 0; dt_kind = 0; dt_nacode = 0;
    if_rid = 0; if_ps = 0; dt_rid = 0; dt_ps = 0;
    repeat (3) @(negedge clk);
    e_addr = 0; e_xinfo = 0; e_stat = 0; e_inst = 0;
    check_caps("R3 reset", 1'b0);
    chk("R1 vector", {48'b0, pf_vec}, 64'h5000);
    rst_n = 1;

    // data sweep: R2 R4 R5 R6 R7 R3
    for (int k = 0; k < 8; k++)
      for (int p = 0; p < 2; p++)
        for (int e = 0; e < 4; e++)
          for (int lg = 0; lg < 2; lg++)
            for (int ed = 0; ed < 2; ed++) begin
              logic ef; int idx;
              idx = ((((k * 2 + p) * 4 + e) * 2 + lg) * 2 + ed);
              @(negedge clk);
              idle();
              dt_en = e[0]; rs_en = e[1]; it_en = 1;
              dt_req = 1; dt_present = p[0]; dt_kind = k[2:0]; dt_legacy = lg[0]; dt_ed = ed[0];
              dt_va = {32'hC0DE_0000 + 32'(idx), 32'h0000_1003 * 32'(idx + 1)};
              dt_nacode = 4'(idx + 5); dt_slot = 2'(idx % 3); dt_ni = idx[2];
              dt_rid = 24'h10_0000 + 24'(idx); dt_ps = 6'(idx % 61);
              ef = !p[0] && (k < 6) && ((k >= 4) ? e[1] : e[0]);
              if (ef) begin
                e_addr = dt_va; e_xinfo = {dt_rid, dt_ps, 2'b00}; e_inst = 0;
                e_stat = dstat(k[2:0], lg[0], dt_nacode, dt_slot, dt_ni, ed[0]);
              end
              @(negedge clk);
              check_caps(ef ? "R6 R7 R2 data fault" : "R2 R3 data no-fault", ef);
              idle();
            end

    // instruction sweep: R5 R8 R2
    for (int p = 0; p < 2; p++)
      for (int en = 0; en < 2; en++)
        for (int lg = 0; lg < 2; lg++)
          for (int sl = 0; sl < 3; sl++) begin
            logic ef; int idx;
            idx = ((p * 2 + en) * 2 + lg) * 3 + sl;
            @(negedge clk);
            idle();
            it_en = en[0]; dt_en = 1; rs_en = 1;
            if_req = 1; if_present = p[0]; if_legacy = lg[0]; if_slot = sl[1:0]; if_ni = 1;
            if_va = 64'hFEDC_BA98_7654_321F ^ (64'(idx) << 8);
            if_rid = 24'hABC000 + 24'(idx); if_ps = 6'(12 + idx);
            ef = !p[0] && en[0];
            if (ef) begin
              e_addr = lg[0] ? {32'b0, if_va[31:4], 4'b0} : if_va;
              e_xinfo = {if_rid, if_ps, 2'b00}; e_inst = 1;
              e_stat = {2'b00, lg[0] ? 2'b00 : sl[1:0], ~lg[0], 4'b0, 1'b1, 2'b00, 4'b0};
            end
            @(negedge clk);
            check_caps(ef ? "R5 R8 inst fault" : "R2 inst no-fault", ef);
            idle();
          end

    // collision: R9
    @(negedge clk);
    it_en = 1; dt_en = 1; rs_en = 1;
    if_req = 1; if_present = 0; if_legacy = 0; if_slot = 2; if_ni = 0;
    if_va = 64'h1111_2222_3333_4440; if_rid = 24'h0000AA; if_ps = 6'd14;
    dt_req = 1; dt_present = 0; dt_kind = 3'd1; dt_legacy = 0; dt_va = 64'h9999_8888_7777_6666;
    dt_rid = 24'h0000BB; dt_ps = 6'd20;
    e_addr = if_va; e_xinfo = {if_rid, if_ps, 2'b00}; e_inst = 1;
    e_stat = {2'b00, 2'b10, 1'b0, 4'b0, 1'b1, 2'b00, 4'b0};
    @(negedge clk);
    check_caps("R9 both fault", 1'b1);
    if_present = 1;
    e_addr = dt_va; e_xinfo = {dt_rid, dt_ps, 2'b00}; e_inst = 0;
    e_stat = dstat(3'd1, 1'b0, dt_nacode, dt_slot, dt_ni, dt_ed);
    @(negedge clk);
    check_caps("R9 fetch clean data faults", 1'b1);
    idle();
    @(negedge clk);
    check_caps("R3 hold", 1'b0);
    chk("R1 vector", {48'b0, pf_vec}, 64'h5000);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule